// File: doc/BRIEF.md
# Quadword Register-Pair Loader

This block carries out a 16-byte load into a pair of adjacent 64-bit registers. A request brings a base register number and the value read from it, a 12-bit displacement counted in 16-byte units, the number of the even destination register, and a byte-order mode bit. The block forms the effective address and fetches the two doublewords through one memory read port, lower address first. It then writes the even and odd registers together in one cycle. The register file and the memory sit outside the block.

Big-endian mode places the doubleword at the effective address into the even register and the one 8 bytes higher into the odd register. Little-endian mode swaps the two doublewords between the registers and reverses the byte order inside each. Two kinds of encoding are rejected: an odd destination number, and a destination that equals the base register. A rejected request makes no memory access and writes no register. A destination equal to the base also raises a request for the illegal-instruction handler.

Requests use a valid/ready handshake, and so does the memory read request. A request is accepted on a cycle with both `req_valid` and `req_ready` high. `req_ready` is high only while the block is idle, so a source must hold its request until that cycle. A memory read request stays raised, with a fixed address, until `mem_req_ready` accepts it. Each accepted read returns exactly one response with `mem_rsp_valid`, one or more cycles later. The block takes the response in the cycle it arrives and cannot stall it.

Top module: `qpair_loader`

## Requirements
- R1: The effective address is the base value plus the displacement shifted left by four bits and sign-extended. A base register number of 0 uses zero in place of the base value.
- R2: A valid request makes exactly two memory reads, at the effective address and then at the effective address plus 8.
- R3: In big-endian mode (`req_le`=0) the even register receives the doubleword read from the effective address. The odd register receives the doubleword read from the effective address plus 8.
- R4: In little-endian mode (`req_le`=1) the even register receives the doubleword from the effective address plus 8, and the odd register the doubleword from the effective address. Both are byte-reversed, so byte 0 (bits 7:0) of memory data lands in bits 63:56.
- R5: A request whose destination number is odd, or equals the base register number (both 0 included), raises `bad_form` for one cycle, one cycle after acceptance. It makes no memory read and no register write.
- R6: `trap_req` pulses together with `bad_form` only when the destination number equals the base register number.
- R7: A valid request writes both registers in one cycle: `pair_wr` is high for exactly one cycle, with `wr_even_idx` set to the destination number and `wr_odd_idx` set to the destination number plus 1.
- R8: `req_ready` is low from the acceptance of a valid request until its write cycle has completed.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays raised on the next cycle with an unchanged address.
- R10: After reset `req_ready` is 1, and `mem_req_valid`, `pair_wr`, `bad_form` and `trap_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_base_idx | input | 5 | Base register number |
| req_base_val | input | 64 | Contents of the base register |
| req_disp | input | 12 | Displacement in 16-byte units |
| req_tgt_idx | input | 5 | Even destination register number |
| req_le | input | 1 | 1 selects little-endian mode |
| mem_req_valid | output | 1 | Doubleword read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 64 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Returned doubleword, byte 0 in bits 7:0 |
| pair_wr | output | 1 | Write both registers; completion pulse |
| wr_even_idx | output | 5 | Even register number |
| wr_even_data | output | 64 | Even register data |
| wr_odd_idx | output | 5 | Odd register number |
| wr_odd_data | output | 64 | Odd register data |
| bad_form | output | 1 | Rejected encoding pulse |
| trap_req | output | 1 | Illegal-instruction handler request pulse |

## Verification
The assertions assume that memory returns one response for each accepted read, no earlier than the cycle after acceptance. They also assume that no response arrives while no read is outstanding. The bench's memory model answers each accepted read exactly one cycle later and never answers on its own. It applies back-pressure either never or on every other cycle, which exercises the address-hold rule without breaking the response assumptions.

// File: rtl/qpl_pkg.sv
package qpl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_LO = 2'd1,
    ST_RD_HI = 2'd2,
    ST_WB    = 2'd3
  } qpl_state_e;
endpackage

// File: rtl/qpl_ea_gen.sv
module qpl_ea_gen #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 12,
  parameter int IDX_W  = 5,
  parameter int SCALE  = 4
) (
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [XLEN-1:0]   base_val,
  input  logic [DISP_W-1:0] disp,
  output logic [XLEN-1:0]   ea
);
  localparam int EXT_W = XLEN - DISP_W - SCALE;

  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] offset;

  // register number zero reads as the constant zero
  assign base_eff = (base_idx == '0) ? '0 : base_val;
  assign offset   = {{EXT_W{disp[DISP_W-1]}}, disp, {SCALE{1'b0}}};
  assign ea       = base_eff + offset;
endmodule

// File: rtl/qpl_form_check.sv
module qpl_form_check #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] tgt_idx,
  input  logic [IDX_W-1:0] base_idx,
  output logic             bad,
  output logic             trap
);
  logic same_reg;

  assign same_reg = (tgt_idx == base_idx);
  assign bad      = tgt_idx[0] | same_reg;
  assign trap     = same_reg;
endmodule

// File: rtl/qpl_steer.sv
module qpl_steer #(
  parameter int XLEN = 64
) (
  input  logic            le_mode,
  input  logic [XLEN-1:0] dw_lo,
  input  logic [XLEN-1:0] dw_hi,
  output logic [XLEN-1:0] even_data,
  output logic [XLEN-1:0] odd_data
);
  localparam int NBYTES = XLEN / 8;

  logic [XLEN-1:0] lo_rev;
  logic [XLEN-1:0] hi_rev;

  for (genvar b = 0; b < NBYTES; b++) begin : g_rev
    assign lo_rev[8*b +: 8] = dw_lo[8*(NBYTES-1-b) +: 8];
    assign hi_rev[8*b +: 8] = dw_hi[8*(NBYTES-1-b) +: 8];
  end

  assign even_data = le_mode ? hi_rev : dw_lo;
  assign odd_data  = le_mode ? lo_rev : dw_hi;
endmodule

// File: rtl/qpair_loader.sv
module qpair_loader
  import qpl_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int DISP_W = 12,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_base_idx,
  input  logic [XLEN-1:0]   req_base_val,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [IDX_W-1:0]  req_tgt_idx,
  input  logic              req_le,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              pair_wr,
  output logic [IDX_W-1:0]  wr_even_idx,
  output logic [XLEN-1:0]   wr_even_data,
  output logic [IDX_W-1:0]  wr_odd_idx,
  output logic [XLEN-1:0]   wr_odd_data,
  output logic              bad_form,
  output logic              trap_req
);
  localparam logic [XLEN-1:0] DW_STEP = XLEN'(XLEN / 8);

  qpl_state_e       state_q;
  logic [XLEN-1:0]  ea_q;
  logic [IDX_W-1:0] tgt_q;
  logic             le_q;
  logic             sent_q;
  logic [XLEN-1:0]  lo_q;
  logic [XLEN-1:0]  hi_q;
  logic             bad_q;
  logic             trap_q;

  logic [XLEN-1:0]  ea_w;
  logic             bad_w;
  logic             trap_w;
  logic             accept;
  logic             rd_fire;
  logic             rsp_take;

  qpl_ea_gen #(.XLEN(XLEN), .DISP_W(DISP_W), .IDX_W(IDX_W)) u_ea (
    .base_idx (req_base_idx),
    .base_val (req_base_val),
    .disp     (req_disp),
    .ea       (ea_w)
  );

  qpl_form_check #(.IDX_W(IDX_W)) u_form (
    .tgt_idx  (req_tgt_idx),
    .base_idx (req_base_idx),
    .bad      (bad_w),
    .trap     (trap_w)
  );

  qpl_steer #(.XLEN(XLEN)) u_steer (
    .le_mode   (le_q),
    .dw_lo     (lo_q),
    .dw_hi     (hi_q),
    .even_data (wr_even_data),
    .odd_data  (wr_odd_data)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid & req_ready;
  assign mem_req_valid = ((state_q == ST_RD_LO) || (state_q == ST_RD_HI)) && !sent_q;
  assign mem_req_addr  = (state_q == ST_RD_HI) ? (ea_q + DW_STEP) : ea_q;
  assign rd_fire       = mem_req_valid & mem_req_ready;
  assign rsp_take      = sent_q & mem_rsp_valid;

  assign pair_wr     = (state_q == ST_WB);
  assign wr_even_idx = tgt_q;
  assign wr_odd_idx  = {tgt_q[IDX_W-1:1], 1'b1};
  assign bad_form    = bad_q;
  assign trap_req    = trap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      tgt_q   <= '0;
      le_q    <= 1'b0;
      sent_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      bad_q   <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      bad_q  <= 1'b0;
      trap_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (bad_w) begin
              bad_q  <= 1'b1;
              trap_q <= trap_w;
            end else begin
              ea_q    <= ea_w;
              tgt_q   <= req_tgt_idx;
              le_q    <= req_le;
              sent_q  <= 1'b0;
              state_q <= ST_RD_LO;
            end
          end
        end
        ST_RD_LO: begin
          if (rd_fire) sent_q <= 1'b1;
          if (rsp_take) begin
            lo_q    <= mem_rsp_data;
            sent_q  <= 1'b0;
            state_q <= ST_RD_HI;
          end
        end
        ST_RD_HI: begin
          if (rd_fire) sent_q <= 1'b1;
          if (rsp_take) begin
            hi_q    <= mem_rsp_data;
            sent_q  <= 1'b0;
            state_q <= ST_WB;
          end
        end
        ST_WB: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R7
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_wr |=> !pair_wr);

  // R5
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_form |-> (!pair_wr && !mem_req_valid && req_ready));

  // R6
  trap_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> bad_form);

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || pair_wr) |-> !req_ready);

  // R5
  bad_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bad_form) |-> $past(req_valid && req_ready));
endmodule

// File: tb/tb_qpair_loader.sv
module tb_qpair_loader;
  localparam int XLEN = 64;
  localparam int NVEC = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_base_idx = '0;
  logic [63:0] req_base_val = '0;
  logic [11:0] req_disp = '0;
  logic [4:0]  req_tgt_idx = '0;
  logic        req_le = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        pair_wr;
  logic [4:0]  wr_even_idx, wr_odd_idx;
  logic [63:0] wr_even_data, wr_odd_data;
  logic        bad_form, trap_req;

  int checks = 0;
  int failures = 0;

  // memory model state
  logic        stall_en = 1'b0;
  logic        tog;
  int          nreq;
  int          hold_err;
  logic [63:0] alog [128];
  logic        prev_stalled;
  logic [63:0] prev_addr;

  always #5 clk = ~clk;

  qpair_loader dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base_idx(req_base_idx), .req_base_val(req_base_val),
    .req_disp(req_disp), .req_tgt_idx(req_tgt_idx), .req_le(req_le),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .pair_wr(pair_wr),
    .wr_even_idx(wr_even_idx), .wr_even_data(wr_even_data),
    .wr_odd_idx(wr_odd_idx), .wr_odd_data(wr_odd_data),
    .bad_form(bad_form), .trap_req(trap_req)
  );

  function automatic logic [63:0] mdat(input logic [63:0] a);
    return {a[31:0], ~a[31:0]} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  function automatic logic [63:0] brev(input logic [63:0] d);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = d[8*(7-b) +: 8];
    return r;
  endfunction

  assign mem_req_ready = !stall_en || tog;

  always @(posedge clk) begin
    if (!rst_n) begin
      tog <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data <= '0;
      nreq <= 0;
      hold_err <= 0;
      prev_stalled <= 1'b0;
      prev_addr <= '0;
    end else begin
      tog <= !tog;
      mem_rsp_valid <= mem_req_valid && mem_req_ready;
      mem_rsp_data <= mdat(mem_req_addr);
      if (prev_stalled && (!mem_req_valid || mem_req_addr != prev_addr))
        hold_err <= hold_err + 1;
      prev_stalled <= mem_req_valid && !mem_req_ready;
      prev_addr <= mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        alog[nreq[6:0]] <= mem_req_addr;
        nreq <= nreq + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {le, tgt, base_idx, disp, base_val}
  localparam logic [86:0] VEC [NVEC] = '{
    {1'b0, 5'd4,  5'd3, 12'h001, 64'h0000_0000_0000_1000},
    {1'b1, 5'd4,  5'd3, 12'h001, 64'h0000_0000_0000_1000},
    {1'b0, 5'd6,  5'd0, 12'h7FF, 64'h0000_0000_0000_DEAD},
    {1'b1, 5'd2,  5'd5, 12'hFFF, 64'h0000_0000_0000_2000},
    {1'b0, 5'd30, 5'd1, 12'h800, 64'h0000_0000_0001_0000},
    {1'b0, 5'd5,  5'd3, 12'h010, 64'h0000_0000_0000_4000},
    {1'b0, 5'd8,  5'd8, 12'h010, 64'h0000_0000_0000_4000},
    {1'b1, 5'd0,  5'd0, 12'h002, 64'h0000_0000_0000_0000},
    {1'b1, 5'd7,  5'd7, 12'h003, 64'h0000_0000_0000_8000}
  };

  task automatic run_op(input logic [86:0] v);
    logic        le = v[86];
    logic [4:0]  tgt = v[85:81];
    logic [4:0]  bidx = v[80:76];
    logic [11:0] d = v[75:64];
    logic [63:0] bval = v[63:0];
    logic [63:0] ea;
    logic [63:0] lo, hi;
    bit          valid, trap, seen_wr, seen_bad, seen_trap, wr_twice;
    int          start;
    logic [4:0]  ei, oi;
    logic [63:0] ed, od;
    ea = ((bidx == 5'd0) ? 64'd0 : bval) + {{48{d[11]}}, d, 4'b0000};
    valid = !tgt[0] && (tgt != bidx);
    trap = (tgt == bidx);
    lo = mdat(ea);
    hi = mdat(ea + 64'd8);
    seen_wr = 0; seen_bad = 0; seen_trap = 0; wr_twice = 0;
    ei = '0; oi = '0; ed = '0; od = '0;
    @(negedge clk);
    start = nreq;
    req_valid = 1'b1; req_le = le; req_tgt_idx = tgt;
    req_base_idx = bidx; req_disp = d; req_base_val = bval;
    @(negedge clk);
    req_valid = 1'b0;
    if (valid) chk(req_ready == 1'b0, "R8 ready low while busy", 64'(req_ready), 64'd0);
    for (int c = 0; c < 40; c++) begin
      if (pair_wr) begin
        if (seen_wr) wr_twice = 1;
        seen_wr = 1; ei = wr_even_idx; oi = wr_odd_idx;
        ed = wr_even_data; od = wr_odd_data;
      end
      if (bad_form) seen_bad = 1;
      if (trap_req) seen_trap = 1;
      if ((seen_wr && !pair_wr) || (!valid && c > 4)) break;
      @(negedge clk);
    end
    if (valid) begin
      chk(seen_wr && !wr_twice, "R7 single write pulse", 64'(seen_wr), 64'd1);
      chk(nreq - start == 2, "R2 read count", 64'(nreq - start), 64'd2);
      chk(alog[start[6:0]] == ea, "R1 first read address", alog[start[6:0]], ea);
      chk(alog[7'(start + 1)] == ea + 64'd8, "R2 second read address",
          alog[7'(start + 1)], ea + 64'd8);
      chk(ei == tgt && oi == (tgt | 5'd1), "R7 write indexes", {ei, oi}, {tgt, tgt | 5'd1});
      if (!le) begin
        chk(ed == lo, "R3 even data", ed, lo);
        chk(od == hi, "R3 odd data", od, hi);
      end else begin
        chk(ed == brev(hi), "R4 even data", ed, brev(hi));
        chk(od == brev(lo), "R4 odd data", od, brev(lo));
      end
      chk(!seen_bad && !seen_trap, "R5 no flag on valid form", 64'(seen_bad), 64'd0);
    end else begin
      chk(seen_bad, "R5 bad_form raised", 64'(seen_bad), 64'd1);
      chk(!seen_wr && (nreq == start), "R5 no access or write",
          64'(nreq - start), 64'd0);
      chk(seen_trap == trap, "R6 trap request", 64'(seen_trap), 64'(trap));
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10 req_ready", 64'(req_ready), 64'd1);
    chk(!mem_req_valid && !pair_wr && !bad_form && !trap_req, "R10 outputs idle",
        {mem_req_valid, pair_wr, bad_form, trap_req}, 64'd0);

    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      for (int i = 0; i < NVEC; i++) run_op(VEC[i]);
    end

    // R9 back-pressure: address held until accepted
    chk(hold_err == 0, "R9 request hold", 64'(hold_err), 64'd0);

    // corner: base register 0 with a negative displacement wraps below zero
    stall_en = 1'b1;
    run_op({1'b1, 5'd10, 5'd0, 12'h800, 64'hFFFF_FFFF_FFFF_FFFF});
    // corner: highest even pair and largest positive displacement
    run_op({1'b0, 5'd30, 5'd31, 12'h7FF, 64'hFFFF_FFFF_FFFF_0000});
    chk(hold_err == 0, "R9 request hold after corners", 64'(hold_err), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule